// File: doc/BRIEF.md
# Digital PLL Lock Qualification Indicator

This block decides when a digital phase-locked loop may report itself as locked. On every sample strobe it takes the signed residual phase error measured by the loop and compares its magnitude with a fixed bound of 20 ns. It raises its lock flag only after a run of consecutive in-bound samples. The length of that run depends on which loop-filter bandwidth is selected. The narrowest filter needs the longest run.

After lock is declared, the block keeps checking every sample. A single sample outside the bound, a change of filter selection or a reset drops the flag and starts qualification again. A two-bit state code is brought out for debug. This block does not measure the phase and does not filter the loop. The sample strobe rate sets how a tick count maps to seconds, so simulation can use a fast strobe.

Top module: `pll_lock_qualifier`

## Requirements
- R1: After reset, `lock` is 0 and `state_dbg` is 2'b00.
- R2: A sample is in bound when the magnitude of `phase_err` is at most 20 (1 LSB = 1 ns). Values of +20 and -20 are in bound. Values of +21 and -21 are out of bound.
- R3: An out-of-bound sample taken on a tick, in any state, clears `lock`, returns `state_dbg` to 2'b00 and restarts the count of consecutive in-bound ticks.
- R4: `lock` rises on the clock edge that takes the Nth consecutive in-bound tick after a restart. N is 65 for `filt_mode` 2'b01 (0.1 Hz filter), 10 for 2'b00 (1.5 Hz filter), and `HOLD_FAST` (default 4) for 2'b10 and 2'b11 (12 Hz and 6 Hz filters).
- R5: A change of `filt_mode` clears `lock`, returns `state_dbg` to 2'b00 and restarts qualification. It takes priority over a tick in the same cycle, and that tick is not counted.
- R6: In cycles without `tick`, `phase_err` is ignored, the count of in-bound ticks is kept, and `lock` and `state_dbg` do not change.
- R7: `state_dbg` reads 2'b00 when unlocked with no in-bound tick counted, 2'b01 while qualifying, and 2'b10 when locked. `lock` is 1 exactly in state 2'b10.
- R8: Once locked, `lock` stays 1 while every tick carries an in-bound sample.
- R9: The most negative `phase_err` value is treated as out of bound. Its magnitude does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample strobe; `phase_err` is valid in this cycle |
| phase_err | input | PHASE_W (16) | Signed residual phase error, 1 ns per LSB |
| filt_mode | input | 2 | Loop-filter selection; sets the qualification length |
| lock | output | 1 | 1 when lock is declared |
| state_dbg | output | 2 | Qualifier state code |

## Verification
The hardest situation to reach is the one where a tick and a filter change arrive in the same cycle. That tick must be thrown away instead of counted. The bench drives both on one edge and then checks that the state code is 2'b00 and not 2'b01. A second hard case is a qualification run that is paused by idle cycles carrying wild phase values. The bench pauses a run partway through with such values, then finishes it, and checks that lock rises on exactly the tick the mode requires. The full 65-tick run of the slowest mode and an out-of-bound sample in the middle of a run are also driven through the vector table.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

  typedef enum logic [1:0] {
    ST_UNLOCKED = 2'b00,
    ST_QUALIFY  = 2'b01,
    ST_LOCKED   = 2'b10
  } lock_state_e;

  localparam logic [1:0] MODE_MED    = 2'b00;
  localparam logic [1:0] MODE_NARROW = 2'b01;

  // magnitude of a sign-extended error; 33 bits so the most negative input cannot wrap
  function automatic logic [32:0] err_mag(input logic signed [32:0] e);
    logic signed [32:0] neg;
    neg = -e;
    return (e < 0) ? neg : e;
  endfunction

  // qualification length in ticks for a filter selection
  function automatic int unsigned hold_for_mode(input logic [1:0] mode,
                                                input int unsigned slow,
                                                input int unsigned med,
                                                input int unsigned fast);
    case (mode)
      MODE_NARROW: return slow;
      MODE_MED:    return med;
      default:     return fast;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lockq_window.sv
module lockq_window #(
  parameter int PHASE_W = 16,
  parameter int THRESH  = 20
) (
  input  logic [PHASE_W-1:0] phase_err,
  output logic               in_bound
);
  import lockq_pkg::*;

  logic signed [32:0] err_ext;
  logic [32:0]        err_abs;

  assign err_ext  = {{(33-PHASE_W){phase_err[PHASE_W-1]}}, phase_err};
  assign err_abs  = err_mag(err_ext);
  assign in_bound = (err_abs <= 33'(THRESH));

endmodule

// File: rtl/lockq_hold_timer.sv
module lockq_hold_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             reached
);

  logic [CNT_W:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reached = advance && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= cnt_inc[CNT_W-1:0];
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/lockq_fsm.sv
module lockq_fsm (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   in_bound,
  input  logic                   mode_change,
  input  logic                   reached,
  output lockq_pkg::lock_state_e state,
  output logic                   advance,
  output logic                   clear
);
  import lockq_pkg::*;

  lock_state_e state_nx;
  logic        bad_tick;

  assign bad_tick = tick && !in_bound;
  assign clear    = mode_change || bad_tick;
  assign advance  = tick && in_bound && !mode_change && (state != ST_LOCKED);

  always_comb begin
    state_nx = state;
    if (clear)        state_nx = ST_UNLOCKED;
    else if (advance) state_nx = reached ? ST_LOCKED : ST_QUALIFY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UNLOCKED;
    else        state <= state_nx;
  end

  // R3
  bad_tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_tick |=> (state == ST_UNLOCKED));

  // R5
  mode_change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> (state == ST_UNLOCKED));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !mode_change) |=> $stable(state));

  // R2
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKED && $past(state) != ST_LOCKED) |-> $past(tick && in_bound));

  // R7
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier #(
  parameter int PHASE_W   = 16,
  parameter int THRESH    = 20,
  parameter int HOLD_SLOW = 65,
  parameter int HOLD_MED  = 10,
  parameter int HOLD_FAST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] phase_err,
  input  logic [1:0]         filt_mode,
  output logic               lock,
  output logic [1:0]         state_dbg
);
  import lockq_pkg::*;

  localparam int HOLD_MAX = int'(max3(HOLD_SLOW, HOLD_MED, HOLD_FAST));
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);

  logic [1:0]       mode_q;
  logic             mode_change;
  logic             in_bound;
  logic             advance;
  logic             clear;
  logic             reached;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] hold_cnt;
  lock_state_e      state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_MED;
    else        mode_q <= filt_mode;
  end

  assign mode_change = (filt_mode != mode_q);
  assign limit = CNT_W'(hold_for_mode(mode_q, HOLD_SLOW, HOLD_MED, HOLD_FAST));

  lockq_window #(.PHASE_W(PHASE_W), .THRESH(THRESH)) u_window (
    .phase_err (phase_err),
    .in_bound  (in_bound)
  );

  lockq_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .advance (advance),
    .limit   (limit),
    .cnt     (hold_cnt),
    .reached (reached)
  );

  lockq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .in_bound    (in_bound),
    .mode_change (mode_change),
    .reached     (reached),
    .state       (state),
    .advance     (advance),
    .clear       (clear)
  );

  assign lock      = (state == ST_LOCKED);
  assign state_dbg = state;

  // R4
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (hold_cnt == limit));

  // R8
  keep_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && tick && in_bound && !mode_change) |=> lock);

endmodule

// File: tb/test_pll_lock_qualifier.sv
module test_pll_lock_qualifier;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] phase_err = '0;
  logic [1:0]  filt_mode = 2'b00;
  logic        lock;
  logic [1:0]  state_dbg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_lock_qualifier i_pll_lock_qualifier (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase_err(phase_err),
    .filt_mode(filt_mode), .lock(lock), .state_dbg(state_dbg)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] err;
    logic [7:0]  n;
    logic        lk;
    logic [1:0]  st;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 16'sd0,      8'd9,  1'b0, 2'b01},  // R4 one short of 10
    '{2'b00, 16'sd20,     8'd1,  1'b1, 2'b10},  // R2 +20 in bound, R4
    '{2'b00, -16'sd20,    8'd5,  1'b1, 2'b10},  // R8, R2 -20
    '{2'b00, 16'sd21,     8'd1,  1'b0, 2'b00},  // R3 +21
    '{2'b00, -16'sd5,     8'd10, 1'b1, 2'b10},  // R4 relock
    '{2'b00, -16'sd21,    8'd1,  1'b0, 2'b00},  // R3 -21
    '{2'b01, 16'sd3,      8'd64, 1'b0, 2'b01},  // R4 slow mode
    '{2'b01, 16'sd3,      8'd1,  1'b1, 2'b10},  // R4 65th tick
    '{2'b10, 16'sd0,      8'd0,  1'b0, 2'b00},  // R5 change drops lock
    '{2'b10, 16'sd7,      8'd3,  1'b0, 2'b01},  // R4 fast mode
    '{2'b10, 16'sd7,      8'd1,  1'b1, 2'b10},  // R4
    '{2'b11, 16'sd0,      8'd4,  1'b1, 2'b10},  // R4 mode 11
    '{2'b11, 16'h8000,    8'd1,  1'b0, 2'b00}   // R9 most negative
  };

  task automatic check(input string req, input logic act_lk, input logic [1:0] act_st,
                       input logic exp_lk, input logic [1:0] exp_st);
    n_chk++;
    if (act_lk !== exp_lk || act_st !== exp_st) begin
      n_fail++;
      $display("FAIL %s lock=%0b state=%0b expected lock=%0b state=%0b",
               req, act_lk, act_st, exp_lk, exp_st);
    end
  endtask

  task automatic do_tick(input logic [15:0] e);
    @(negedge clk);
    tick = 1'b1;
    phase_err = e;
    @(negedge clk);
    tick = 1'b0;
    phase_err = 16'h7fff;
  endtask

  task automatic set_mode(input logic [1:0] m);
    if (m != filt_mode) begin
      @(negedge clk);
      filt_mode = m;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", lock, state_dbg, 1'b0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", lock, state_dbg, 1'b0, 2'b00);

    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].mode);
      for (int k = 0; k < int'(VECS[i].n); k++) do_tick(VECS[i].err);
      check($sformatf("vector %0d (R2/R3/R4/R5/R8/R9)", i), lock, state_dbg,
            VECS[i].lk, VECS[i].st);
    end

    // R6: idle cycles with wild phase do not disturb a run
    set_mode(2'b00);
    do_tick(16'h0000);
    for (int k = 0; k < 4; k++) do_tick(16'h0001);
    @(negedge clk);
    tick = 1'b0;
    phase_err = 16'h8000;
    repeat (6) @(negedge clk);
    check("R6 idle keeps state", lock, state_dbg, 1'b0, 2'b01);
    for (int k = 0; k < 4; k++) do_tick(16'h0002);
    check("R6 count kept (9 of 10)", lock, state_dbg, 1'b0, 2'b01);
    do_tick(16'h0000);
    check("R6 lock on 10th", lock, state_dbg, 1'b1, 2'b10);

    // R5: mode change and tick in the same cycle, tick discarded
    @(negedge clk);
    filt_mode = 2'b10;
    tick = 1'b1;
    phase_err = 16'h0000;
    @(negedge clk);
    tick = 1'b0;
    check("R5 tick dropped on change", lock, state_dbg, 1'b0, 2'b00);
    for (int k = 0; k < 3; k++) do_tick(16'h0000);
    check("R5 restart count 3 of 4", lock, state_dbg, 1'b0, 2'b01);
    do_tick(16'h0000);
    check("R5 lock on 4th", lock, state_dbg, 1'b1, 2'b10);

    // R3: bad sample mid-qualification restarts the count
    set_mode(2'b00);
    for (int k = 0; k < 5; k++) do_tick(16'h0000);
    do_tick(16'd40);
    check("R3 mid-run drop", lock, state_dbg, 1'b0, 2'b00);
    for (int k = 0; k < 9; k++) do_tick(16'h0000);
    check("R3 restart 9 of 10", lock, state_dbg, 1'b0, 2'b01);
    do_tick(16'h0000);
    check("R3 lock after restart", lock, state_dbg, 1'b1, 2'b10);

    // R1: reset while locked
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset when locked", lock, state_dbg, 1'b0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset", lock, state_dbg, 1'b0, 2'b00);

    finish_run();
  end

endmodule